// File: doc/BRIEF.md
# Lock-Elision Prefix Hint Resolver

This decode-stage block watches an instruction arriving one byte per cycle and decides whether the instruction carries a lock-elision hint. The two repeat-type prefix bytes act as the hints: 0xF2 asks for elision to start (acquire) and 0xF3 asks for it to end (release). When both appear before the opcode, the one seen last, closest to the opcode, decides. Other legacy prefixes may sit between them without disturbing the tracked hint. Once the opcode byte has been seen, later bytes of the instruction no longer affect the hint.

A per-instruction capability flag says whether the opcode accepts the hint, and a global feature enable can switch hint recognition off. In both cases the prefixes keep their legacy meaning and the result is "none". The block also counts the bytes of the instruction. An instruction longer than the architectural limit raises a general-protection fault in place of a hint. The result is registered and appears for one cycle, one clock after the byte marked last.

Top module: `elide_hint_resolver`

## Requirements
- R1: A 0xF2 byte that is the last repeat-type prefix before the opcode, on a capable opcode with the feature enabled, gives result code 1 (acquire) on `res_hint_o`.
- R2: A 0xF3 byte that is the last repeat-type prefix before the opcode gives result code 2 (release) under the same conditions. Code 3 never appears.
- R3: When both 0xF2 and 0xF3 are present before the opcode, the one nearer the opcode decides. F3,F2,op gives acquire and F2,F3,op gives release.
- R4: The bytes 0xF0, 0x66, 0x67, 0x2E, 0x36, 0x3E, 0x26, 0x64 and 0x65 count as prefixes and do not change or clear the tracked hint.
- R5: With `hint_capable_i` low on the last byte, the result is code 0 (none).
- R6: With `feat_en_i` low on the last byte, the result is code 0 (none), whatever prefixes are present.
- R7: For byte streams containing no byte in 0x40..0x4F, `mode64_i` has no effect on the result.
- R8: Bytes that come after the opcode byte (the first byte that is not a prefix) never change the result, even if they are 0xF2 or 0xF3.
- R9: With `mode64_i` high, bytes 0x40..0x4F before the opcode are prefixes and keep the tracked hint. With `mode64_i` low, such a byte is the opcode.
- R10: An instruction of more than MAX_LEN (15) bytes gives `res_fault_o`=1 with code 0. Exactly 15 bytes gives no fault.
- R11: `res_vld_o` is high for exactly the one cycle after a byte with `byte_vld_i` and `byte_last_i` both high. When `res_vld_o` is low, `res_hint_o` and `res_fault_o` are zero.
- R12: A synchronous reset clears the outputs, the tracked prefix and the byte count, so a partial instruction cut off by reset does not affect the next one.
- R13: An instruction made only of prefix bytes (no opcode) gives code 0 and no fault when it is no longer than MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| byte_vld_i | input | 1 | The instruction byte on `byte_i` is valid this cycle |
| byte_i | input | 8 | Instruction byte |
| byte_last_i | input | 1 | Marks the final byte of the instruction |
| hint_capable_i | input | 1 | The opcode accepts elision hints (sampled on the last byte) |
| feat_en_i | input | 1 | Hint recognition enabled (sampled on the last byte) |
| mode64_i | input | 1 | 64-bit mode; only makes 0x40..0x4F prefix bytes |
| res_vld_o | output | 1 | One-cycle pulse carrying the result |
| res_hint_o | output | 2 | 0 none, 1 acquire, 2 release |
| res_fault_o | output | 1 | Instruction-length general-protection fault |

## Verification
Directed streams cover each hint byte alone, both orderings of the two hint bytes, hints interleaved with other prefixes, and hint-like bytes after the opcode. Together these show that the nearest-to-opcode rule is applied and that it stops at the opcode. The same streams run with the capability flag, the feature enable and the mode bit changed, which shows that each gate forces "none" and that mode matters only for the 0x40..0x4F range. Lengths of 15, 16 and 20 bytes mark the fault boundary, and a reset in the middle of an instruction shows that the state is cleared. Random instructions with random prefix mixes, tails, gaps and controls are then checked against a bench model.

// File: rtl/elide_hint_pkg.sv
package elide_hint_pkg;

   typedef enum logic [1:0] {
      HINT_NONE = 2'd0,
      HINT_ACQ  = 2'd1,
      HINT_REL  = 2'd2
   } hint_e;

   localparam logic [7:0] ACQ_PFX = 8'hF2;
   localparam logic [7:0] REL_PFX = 8'hF3;

   // Legacy prefixes that neither start an opcode nor carry a hint.
   function automatic logic is_plain_prefix(input logic [7:0] b);
      logic r;
      case (b)
         8'hF0, 8'h66, 8'h67,
         8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65: r = 1'b1;
         default:                                  r = 1'b0;
      endcase
      return r;
   endfunction

   // Register-extension byte range used as prefixes in 64-bit mode.
   function automatic logic is_rex_byte(input logic [7:0] b);
      return (b[7:4] == 4'h4);
   endfunction

endpackage

// File: rtl/elide_prefix_tracker.sv
module elide_prefix_tracker
   import elide_hint_pkg::*;
#(
   parameter bit REX_AWARE = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       vld_i,
   input  logic [7:0] data_i,
   input  logic       last_i,
   input  logic       mode64_i,
   output hint_e      rep_nxt_o,
   output logic       opc_nxt_o
);

   hint_e rep_q;
   logic  opc_q;
   logic  rex_pfx;
   logic  pfx_hold;

   generate
      if (REX_AWARE) begin : g_rex
         assign rex_pfx = mode64_i & is_rex_byte(data_i);
      end else begin : g_norex
         logic unused_mode;
         assign unused_mode = mode64_i;
         assign rex_pfx     = 1'b0;
      end
   endgenerate

   assign pfx_hold = is_plain_prefix(data_i) | rex_pfx;

   always_comb begin
      rep_nxt_o = rep_q;
      opc_nxt_o = opc_q;
      if (vld_i && !opc_q) begin
         if (data_i == ACQ_PFX) begin
            rep_nxt_o = HINT_ACQ;
         end else if (data_i == REL_PFX) begin
            rep_nxt_o = HINT_REL;
         end else if (!pfx_hold) begin
            opc_nxt_o = 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rep_q <= HINT_NONE;
         opc_q <= 1'b0;
      end else if (vld_i) begin
         if (last_i) begin
            rep_q <= HINT_NONE;
            opc_q <= 1'b0;
         end else begin
            rep_q <= rep_nxt_o;
            opc_q <= opc_nxt_o;
         end
      end
   end

   AST_OPC_FREEZES_REP: assert property (@(posedge clk_i) disable iff (rst_i)
      (opc_q && !(vld_i && last_i)) |=> $stable(rep_q)); // R8

   AST_INSTR_END_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
      (vld_i && last_i) |=> (rep_q == HINT_NONE && !opc_q)); // R12

endmodule

// File: rtl/elide_len_guard.sv
module elide_len_guard #(
   parameter int MAX_LEN = 15
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic vld_i,
   input  logic last_i,
   output logic over_nxt_o
);

   localparam int            CW  = $clog2(MAX_LEN + 2);
   localparam logic [CW-1:0] SAT = CW'(MAX_LEN + 1);
   localparam logic [CW-1:0] LIM = CW'(MAX_LEN);

   generate
      if (MAX_LEN < 1) begin : g_bad_len
         $error("elide_len_guard: MAX_LEN must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;

   always_comb begin
      cnt_nxt = cnt_q;
      if (vld_i && cnt_q != SAT) begin
         cnt_nxt = cnt_q + 1'b1;
      end
   end

   assign over_nxt_o = (cnt_nxt > LIM);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (vld_i) begin
         cnt_q <= last_i ? '0 : cnt_nxt;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= SAT); // R10

   AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
      (vld_i && last_i) |=> (cnt_q == '0)); // R12

endmodule

// File: rtl/elide_hint_select.sv
module elide_hint_select
   import elide_hint_pkg::*;
(
   input  hint_e rep_i,
   input  logic  opc_seen_i,
   input  logic  over_i,
   input  logic  capable_i,
   input  logic  feat_en_i,
   output hint_e hint_o,
   output logic  fault_o
);

   always_comb begin
      fault_o = over_i;
      hint_o  = HINT_NONE;
      if (!over_i && feat_en_i && capable_i && opc_seen_i) begin
         hint_o = rep_i;
      end
   end

endmodule

// File: rtl/elide_hint_resolver.sv
module elide_hint_resolver
   import elide_hint_pkg::*;
#(
   parameter int MAX_LEN   = 15,
   parameter bit REX_AWARE = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       byte_vld_i,
   input  logic [7:0] byte_i,
   input  logic       byte_last_i,
   input  logic       hint_capable_i,
   input  logic       feat_en_i,
   input  logic       mode64_i,
   output logic       res_vld_o,
   output logic [1:0] res_hint_o,
   output logic       res_fault_o
);

   hint_e rep_nxt;
   logic  opc_nxt;
   logic  over_nxt;
   hint_e sel_hint;
   logic  sel_fault;
   logic  fin;

   assign fin = byte_vld_i & byte_last_i;

   elide_prefix_tracker #(.REX_AWARE(REX_AWARE)) u_track (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .vld_i     (byte_vld_i),
      .data_i    (byte_i),
      .last_i    (byte_last_i),
      .mode64_i  (mode64_i),
      .rep_nxt_o (rep_nxt),
      .opc_nxt_o (opc_nxt)
   );

   elide_len_guard #(.MAX_LEN(MAX_LEN)) u_len (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .vld_i      (byte_vld_i),
      .last_i     (byte_last_i),
      .over_nxt_o (over_nxt)
   );

   elide_hint_select u_sel (
      .rep_i      (rep_nxt),
      .opc_seen_i (opc_nxt),
      .over_i     (over_nxt),
      .capable_i  (hint_capable_i),
      .feat_en_i  (feat_en_i),
      .hint_o     (sel_hint),
      .fault_o    (sel_fault)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         res_vld_o   <= 1'b0;
         res_hint_o  <= HINT_NONE;
         res_fault_o <= 1'b0;
      end else begin
         res_vld_o   <= fin;
         res_hint_o  <= fin ? sel_hint  : HINT_NONE;
         res_fault_o <= fin ? sel_fault : 1'b0;
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
      !res_vld_o |-> (res_hint_o == 2'd0 && !res_fault_o)); // R11

   AST_PULSE_SOURCE: assert property (@(posedge clk_i) disable iff (rst_i)
      res_vld_o |-> $past(byte_vld_i && byte_last_i)); // R11

   AST_FAULT_NO_HINT: assert property (@(posedge clk_i) disable iff (rst_i)
      res_fault_o |-> (res_hint_o == 2'd0)); // R10

   AST_FEATURE_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
      (res_vld_o && $past(!feat_en_i)) |-> (res_hint_o == 2'd0)); // R6

   AST_NOT_CAPABLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (res_vld_o && $past(!hint_capable_i)) |-> (res_hint_o == 2'd0)); // R5

   AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
      res_hint_o != 2'd3); // R2

endmodule

// File: tb/elide_hint_resolver_tb.sv
module elide_hint_resolver_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic       byte_vld;
   logic [7:0] byte_d;
   logic       byte_last;
   logic       capable;
   logic       feat_en;
   logic       mode64;
   logic       res_vld;
   logic [1:0] res_hint;
   logic       res_fault;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] ibuf [0:23];
   int ilen = 0;
   bit gaps = 1'b0;

   always #5 clk = ~clk;

   elide_hint_resolver dut_i (
      .clk_i          (clk),
      .rst_i          (rst),
      .byte_vld_i     (byte_vld),
      .byte_i         (byte_d),
      .byte_last_i    (byte_last),
      .hint_capable_i (capable),
      .feat_en_i      (feat_en),
      .mode64_i       (mode64),
      .res_vld_o      (res_vld),
      .res_hint_o     (res_hint),
      .res_fault_o    (res_fault)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit plain_pfx(input logic [7:0] b);
      return b inside {8'hF0, 8'h66, 8'h67, 8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65};
   endfunction

   // Expected {fault, hint} from the requirements.
   function automatic logic [2:0] model(input bit m64, input bit fe, input bit cp);
      logic [1:0] rep = 2'd0;
      bit opc = 1'b0;
      for (int i = 0; i < ilen; i++) begin
         if (!opc) begin
            if (ibuf[i] == 8'hF2) rep = 2'd1;
            else if (ibuf[i] == 8'hF3) rep = 2'd2;
            else if (plain_pfx(ibuf[i])) rep = rep;
            else if (m64 && ibuf[i][7:4] == 4'h4) rep = rep;
            else opc = 1'b1;
         end
      end
      if (ilen > 15) return 3'b100;
      if (!fe || !cp || !opc) return 3'b000;
      return {1'b0, rep};
   endfunction

   task automatic put(input logic [7:0] b);
      ibuf[ilen] = b;
      ilen++;
   endtask

   task automatic run(input string tag, input bit m64, input bit fe, input bit cp);
      logic [2:0] exp;
      exp = model(m64, fe, cp);
      for (int i = 0; i < ilen; i++) begin
         if (gaps && ($urandom % 4 == 0)) begin
            @(negedge clk);
            byte_vld = 1'b0;
         end
         @(negedge clk);
         byte_vld  = 1'b1;
         byte_d    = ibuf[i];
         byte_last = (i == ilen - 1);
         capable   = cp;
         feat_en   = fe;
         mode64    = m64;
      end
      @(negedge clk);
      check({tag, " valid"}, res_vld, 1);
      check({tag, " hint"}, res_hint, exp[1:0]);
      check({tag, " fault"}, res_fault, exp[2]);
      byte_vld  = 1'b0;
      byte_last = 1'b0;
      @(negedge clk);
      check("R11 pulse drop", res_vld, 0);
      ilen = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4177));
      rst = 1'b1; byte_vld = 1'b0; byte_d = 8'h00; byte_last = 1'b0;
      capable = 1'b1; feat_en = 1'b1; mode64 = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R11 reset valid", res_vld, 0);
      check("R11 reset hint", res_hint, 0);
      check("R11 reset fault", res_fault, 0);

      put(8'hF2); put(8'h86);                    run("R1 acquire", 0, 1, 1);
      put(8'hF3); put(8'h87);                    run("R2 release", 0, 1, 1);
      put(8'hF3); put(8'hF2); put(8'hC6);        run("R3 F3F2 acq", 0, 1, 1);
      put(8'hF2); put(8'hF3); put(8'hF0); put(8'h87); run("R3 F2F3 rel", 0, 1, 1);
      put(8'hF2); put(8'hF0); put(8'h66); put(8'h2E); put(8'h87); run("R4 mixed acq", 0, 1, 1);
      put(8'hF3); put(8'h65); put(8'h36); put(8'h87); run("R4 mixed rel", 1, 1, 1);
      put(8'hF2); put(8'h86);                    run("R5 not capable", 0, 1, 0);
      put(8'hF3); put(8'hF2); put(8'h86);        run("R6 feature off", 1, 0, 1);
      put(8'hF3); put(8'hF2); put(8'hC6);        run("R7 mode32", 0, 1, 1);
      put(8'hF3); put(8'hF2); put(8'hC6);        run("R7 mode64", 1, 1, 1);
      put(8'hF3); put(8'h0F); put(8'hF2); put(8'hF2); run("R8 after opcode", 0, 1, 1);
      put(8'hF2); put(8'h48); put(8'hF3); put(8'h87); run("R9 rex mode64", 1, 1, 1);
      put(8'hF2); put(8'h48); put(8'hF3); put(8'h87); run("R9 rex mode32", 0, 1, 1);
      put(8'hF2); put(8'h87); for (int i = 0; i < 13; i++) put(8'h00); run("R10 len15", 0, 1, 1);
      put(8'hF2); put(8'h87); for (int i = 0; i < 14; i++) put(8'h00); run("R10 len16", 0, 1, 1);
      for (int i = 0; i < 20; i++) put(8'hF3);   run("R10 len20", 0, 1, 1);
      put(8'hF2); put(8'hF3);                    run("R13 no opcode", 0, 1, 1);

      // R12: cut an instruction with reset, then send a fresh one.
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         byte_vld = 1'b1; byte_d = (i == 0) ? 8'hF2 : 8'h66; byte_last = 1'b0;
      end
      @(negedge clk);
      byte_vld = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 10; i++) put(8'h66);
      put(8'h87);                                run("R12 after reset", 0, 1, 1);

      gaps = 1'b1;
      for (int n = 0; n < 400; n++) begin
         bit m64, fe, cp;
         string tag;
         logic [2:0] e;
         int np, nt;
         m64 = $urandom % 2;
         fe  = ($urandom % 6) != 0;
         cp  = ($urandom % 5) != 0;
         np  = $urandom % 6;
         for (int k = 0; k < np; k++) begin
            case ($urandom % 8)
               0, 1:    put(8'hF2);
               2, 3:    put(8'hF3);
               4:       put(8'hF0);
               5:       put(8'h66);
               6:       put(8'h2E);
               default: put(8'h40 | 8'($urandom % 16));
            endcase
         end
         if (($urandom % 10) != 0 || ilen == 0) begin
            put(8'h86 + 8'($urandom % 3));
            nt = $urandom % 14;
            for (int k = 0; k < nt; k++) put(8'($urandom));
         end
         e = model(m64, fe, cp);
         if (e[2]) tag = "R10 random";
         else if (!fe) tag = "R6 random";
         else if (!cp) tag = "R5 random";
         else tag = "R3 random";
         run(tag, m64, fe, cp);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule